// File: doc/BRIEF.md
# Busy-Cycle Resource Release Tracker

This block keeps track of how long execution units and reserved unit groups stay busy after an operation is issued to them. Each accepted usage record names a resource key (a bit mask), the unit picked inside it and a cycle count. The count is added to a per-key busy counter held in a small fixed-depth table. A new entry is opened when the key is not already present.

A cycle tick lowers every live counter by one. Entries that reach zero are streamed out on a freed-entry port, one per clock, lowest table slot first, and the last beat of the burst is marked. Each beat also says whether the single unit behind the key has to be released, which is the case when the key is one-hot. A usage with a zero cycle count never enters the table and is released at once on a separate port. A usage that reserves a whole group is stored under the group mask, used as both resource and unit, and is reported on a reservation port. An issue that finds neither a matching entry nor a free slot is dropped and flagged.

Top module: `busy_release_tracker`

## Requirements
- R1: An accepted usage whose key (resource, unit) matches a live entry adds its cycle count to that entry, so the key is reported once, after the summed number of ticks. At most one live entry matches any key.
- R2: A usage with a cycle count of 0 pulses `imm_rel_valid_o` with `imm_rel_res_o` equal to its resource in the cycle after the issue edge. It creates no table entry, never appears on the freed stream and never causes an overflow.
- R3: A usage with `use_rsv_i`=1 is keyed as (resource, resource) and `use_unit_i` is ignored. One cycle after the issue edge it pulses `rsv_valid_o` with `rsv_mask_o` equal to the resource.
- R4: Every accepted tick lowers each live counter by exactly one. An entry created on the same edge as a tick is not lowered by that tick.
- R5: The entry whose counter reaches zero appears on the freed stream with its resource and unit. `free_unit_rel_o` is 1 exactly when the resource has a single bit set.
- R6: The entries freed by one tick are streamed from the cycle after that tick edge, one beat per cycle, in ascending slot order and without gaps. `free_last_o` is 1 only on the final beat.
- R7: A tick that arrives while freed entries are still waiting to be streamed has no effect on any counter.
- R8: A nonzero usage with no matching entry and no free slot is dropped, and `overflow_o` pulses in the next cycle. An entry waiting to be streamed still occupies its slot.
- R9: After reset the table is empty and every output is 0.
- R10: A new entry takes the lowest-numbered free slot, so it is reported ahead of entries in higher slots that free on the same tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| use_valid_i | input | 1 | Usage record present this cycle |
| use_res_i | input | RES_W | Resource key mask (unit bit or group mask) |
| use_unit_i | input | RES_W | Chosen unit inside the resource |
| use_cycles_i | input | CNT_W | Busy cycles for this usage |
| use_rsv_i | input | 1 | Usage reserves the whole group |
| tick_i | input | 1 | Cycle tick |
| imm_rel_valid_o | output | 1 | Zero-length usage released |
| imm_rel_res_o | output | RES_W | Resource of the zero-length usage |
| rsv_valid_o | output | 1 | Group reservation accepted |
| rsv_mask_o | output | RES_W | Reserved group mask |
| overflow_o | output | 1 | Previous usage dropped, table full |
| free_valid_o | output | 1 | Freed-entry beat valid |
| free_res_o | output | RES_W | Freed entry resource key |
| free_unit_o | output | RES_W | Freed entry unit |
| free_last_o | output | 1 | Last freed beat of this tick |
| free_unit_rel_o | output | 1 | Freed key is a single unit, so the unit is released |

## Verification
The immediate release, reservation and overflow outputs are all due one edge after the issue edge. The bench reads them at the falling edge that follows the issue, before any new stimulus. A freed beat needs two edges after the tick that empties a counter: one edge moves the entry into the waiting state and the next registers the beat. The bench therefore checks that the stream is silent right after each tick and expects the beat one idle clock later, with each further beat one clock after the one before. Counts from 1 to 8 are swept and each release is checked against that arithmetic, and directed sequences cover merging, full-table rejection, ignored ticks and slot ordering.

// File: rtl/busytrk_pkg.sv
package busytrk_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_BUSY = 2'd1,
    SLOT_PEND = 2'd2
  } slot_state_e;
endpackage

// File: rtl/bt_first_set.sv
module bt_first_set #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // lowest set bit wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/bt_slot.sv
module bt_slot
  import busytrk_pkg::*;
#(
  parameter int RES_W = 8,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en_i,
  input  logic             alloc_i,
  input  logic             add_i,
  input  logic             clr_i,
  input  logic [RES_W-1:0] key_res_i,
  input  logic [RES_W-1:0] key_unit_i,
  input  logic [CNT_W-1:0] add_cnt_i,
  output logic             hit_o,
  output logic             free_o,
  output logic             pend_o,
  output logic [RES_W-1:0] res_o,
  output logic [RES_W-1:0] unit_o
);
  slot_state_e      st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_dec;
  logic             zero_now;

  assign cnt_dec  = (st == SLOT_BUSY && tick_en_i) ? cnt - 1'b1 : cnt;
  assign zero_now = (st == SLOT_BUSY) && tick_en_i && (cnt == CNT_W'(1));
  assign hit_o    = (st == SLOT_BUSY) && !zero_now &&
                    (res_o == key_res_i) && (unit_o == key_unit_i);
  assign free_o   = (st == SLOT_FREE);
  assign pend_o   = (st == SLOT_PEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SLOT_FREE;
      cnt    <= '0;
      res_o  <= '0;
      unit_o <= '0;
    end else begin
      unique case (st)
        SLOT_FREE: if (alloc_i) begin
          st     <= SLOT_BUSY;
          cnt    <= add_cnt_i;
          res_o  <= key_res_i;
          unit_o <= key_unit_i;
        end
        SLOT_BUSY: begin
          if (add_i)         cnt <= cnt_dec + add_cnt_i;
          else if (zero_now) begin
            st  <= SLOT_PEND;
            cnt <= '0;
          end else           cnt <= cnt_dec;
        end
        SLOT_PEND: if (clr_i) st <= SLOT_FREE;
        default:   st <= SLOT_FREE;
      endcase
    end
  end

  // R2: a live entry never holds a zero count
  p_busy_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    (st == SLOT_BUSY) |-> (cnt != '0));

  // R4: one accepted tick lowers a live counter by exactly one
  p_tick_dec_r4: assert property (@(posedge clk) disable iff (rst)
    (st == SLOT_BUSY && tick_en_i && !add_i && cnt > CNT_W'(1))
    |=> (st == SLOT_BUSY && cnt == $past(cnt) - 1'b1));

  // R5: reaching zero moves the entry to waiting-for-report
  p_zero_pend_r5: assert property (@(posedge clk) disable iff (rst)
    (st == SLOT_BUSY && tick_en_i && cnt == CNT_W'(1)) |=> (st == SLOT_PEND));
endmodule

// File: rtl/busy_release_tracker.sv
module busy_release_tracker #(
  parameter int DEPTH = 4,
  parameter int RES_W = 8,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             use_valid_i,
  input  logic [RES_W-1:0] use_res_i,
  input  logic [RES_W-1:0] use_unit_i,
  input  logic [CNT_W-1:0] use_cycles_i,
  input  logic             use_rsv_i,
  input  logic             tick_i,
  output logic             imm_rel_valid_o,
  output logic [RES_W-1:0] imm_rel_res_o,
  output logic             rsv_valid_o,
  output logic [RES_W-1:0] rsv_mask_o,
  output logic             overflow_o,
  output logic             free_valid_o,
  output logic [RES_W-1:0] free_res_o,
  output logic [RES_W-1:0] free_unit_o,
  output logic             free_last_o,
  output logic             free_unit_rel_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [RES_W-1:0] key_unit;
  logic             use_ok, any_hit, has_free, reject, draining, tick_en;
  logic [DEPTH-1:0] hit_vec, free_vec, pend_vec, alloc_vec, add_vec, clr_vec;
  logic [IDX_W-1:0] free_idx, pick_idx;
  logic [RES_W-1:0] slot_res  [DEPTH];
  logic [RES_W-1:0] slot_unit [DEPTH];

  assign key_unit = use_rsv_i ? use_res_i : use_unit_i;
  assign use_ok   = use_valid_i && (use_cycles_i != '0);
  assign any_hit  = |hit_vec;
  assign reject   = use_ok && !any_hit && !has_free;
  assign tick_en  = tick_i && !draining;

  assign add_vec   = use_ok ? hit_vec : '0;
  assign alloc_vec = (use_ok && !any_hit && has_free) ? (DEPTH'(1) << free_idx) : '0;
  assign clr_vec   = draining ? (DEPTH'(1) << pick_idx) : '0;

  bt_first_set #(.N(DEPTH), .IW(IDX_W)) u_free_pick (
    .vec_i(free_vec), .found_o(has_free), .idx_o(free_idx));

  bt_first_set #(.N(DEPTH), .IW(IDX_W)) u_drain_pick (
    .vec_i(pend_vec), .found_o(draining), .idx_o(pick_idx));

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    bt_slot #(.RES_W(RES_W), .CNT_W(CNT_W)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .tick_en_i  (tick_en),
      .alloc_i    (alloc_vec[g]),
      .add_i      (add_vec[g]),
      .clr_i      (clr_vec[g]),
      .key_res_i  (use_res_i),
      .key_unit_i (key_unit),
      .add_cnt_i  (use_cycles_i),
      .hit_o      (hit_vec[g]),
      .free_o     (free_vec[g]),
      .pend_o     (pend_vec[g]),
      .res_o      (slot_res[g]),
      .unit_o     (slot_unit[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      imm_rel_valid_o <= 1'b0;
      imm_rel_res_o   <= '0;
      rsv_valid_o     <= 1'b0;
      rsv_mask_o      <= '0;
      overflow_o      <= 1'b0;
      free_valid_o    <= 1'b0;
      free_res_o      <= '0;
      free_unit_o     <= '0;
      free_last_o     <= 1'b0;
      free_unit_rel_o <= 1'b0;
    end else begin
      imm_rel_valid_o <= use_valid_i && (use_cycles_i == '0);
      imm_rel_res_o   <= use_res_i;
      rsv_valid_o     <= use_ok && use_rsv_i && !reject;
      rsv_mask_o      <= use_res_i;
      overflow_o      <= reject;
      free_valid_o    <= draining;
      free_res_o      <= draining ? slot_res[pick_idx]  : '0;
      free_unit_o     <= draining ? slot_unit[pick_idx] : '0;
      free_last_o     <= draining && ($countones(pend_vec) == 1);
      free_unit_rel_o <= draining && $onehot(slot_res[pick_idx]);
    end
  end

  // R1: a key lives in at most one slot
  p_single_match_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R6: freed beats come back to back until the marked one
  p_stream_cont_r6: assert property (@(posedge clk) disable iff (rst)
    (free_valid_o && !free_last_o) |=> free_valid_o);

  // R7: no tick can start a new burst right behind a final beat
  p_stream_end_r7: assert property (@(posedge clk) disable iff (rst)
    (free_valid_o && free_last_o) |=> !free_valid_o);
endmodule

// File: tb/busy_release_tracker_tb.sv
module busy_release_tracker_tb_top;
  localparam int DEPTH = 4;
  localparam int RES_W = 8;
  localparam int CNT_W = 6;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             use_valid_i = 1'b0;
  logic [RES_W-1:0] use_res_i = '0;
  logic [RES_W-1:0] use_unit_i = '0;
  logic [CNT_W-1:0] use_cycles_i = '0;
  logic             use_rsv_i = 1'b0;
  logic             tick_i = 1'b0;
  logic             imm_rel_valid_o, rsv_valid_o, overflow_o;
  logic             free_valid_o, free_last_o, free_unit_rel_o;
  logic [RES_W-1:0] imm_rel_res_o, rsv_mask_o, free_res_o, free_unit_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  busy_release_tracker #(.DEPTH(DEPTH), .RES_W(RES_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst),
    .use_valid_i(use_valid_i), .use_res_i(use_res_i), .use_unit_i(use_unit_i),
    .use_cycles_i(use_cycles_i), .use_rsv_i(use_rsv_i), .tick_i(tick_i),
    .imm_rel_valid_o(imm_rel_valid_o), .imm_rel_res_o(imm_rel_res_o),
    .rsv_valid_o(rsv_valid_o), .rsv_mask_o(rsv_mask_o), .overflow_o(overflow_o),
    .free_valid_o(free_valid_o), .free_res_o(free_res_o), .free_unit_o(free_unit_o),
    .free_last_o(free_last_o), .free_unit_rel_o(free_unit_rel_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic [RES_W-1:0] r, input logic [RES_W-1:0] u,
                       input int cyc, input logic rsv, input logic tk);
    use_valid_i = 1'b1; use_res_i = r; use_unit_i = u;
    use_cycles_i = CNT_W'(cyc); use_rsv_i = rsv; tick_i = tk;
    step();
    use_valid_i = 1'b0; use_rsv_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic tick1();
    tick_i = 1'b1;
    step();
    tick_i = 1'b0;
  endtask

  task automatic beat(input string req, input logic [RES_W-1:0] r, input logic [RES_W-1:0] u,
                      input logic last, input logic urel);
    chk({req, " beat valid"}, 32'(free_valid_o), 32'd1);
    chk({req, " beat res"},   32'(free_res_o), 32'(r));
    chk({req, " beat unit"},  32'(free_unit_o), 32'(u));
    chk({req, " beat last"},  32'(free_last_o), 32'(last));
    chk({req, " beat urel"},  32'(free_unit_rel_o), 32'(urel));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9 free_valid", 32'(free_valid_o), 0);
    chk("R9 imm_rel",    32'(imm_rel_valid_o), 0);
    chk("R9 rsv",        32'(rsv_valid_o), 0);
    chk("R9 overflow",   32'(overflow_o), 0);
    step();
    chk("R9 still idle", 32'(free_valid_o), 0);

    // R4 R5 sweep of counts 1..8 on single units
    for (int n = 1; n <= 8; n++) begin
      logic [RES_W-1:0] m;
      m = RES_W'(1) << (n % RES_W);
      issue(m, m, n, 1'b0, 1'b0);
      for (int t = 1; t <= n; t++) begin
        tick1();
        chk("R4 no beat before release", 32'(free_valid_o), 0);
      end
      step();
      beat("R5 sweep", m, m, 1'b1, 1'b1);
      step();
      chk("R6 single beat burst", 32'(free_valid_o), 0);
    end

    // R2 zero-length usage
    issue(8'h10, 8'h10, 0, 1'b0, 1'b0);
    chk("R2 imm valid", 32'(imm_rel_valid_o), 1);
    chk("R2 imm res",   32'(imm_rel_res_o), 32'h10);
    tick1();
    chk("R2 imm pulse ends", 32'(imm_rel_valid_o), 0);
    step();
    chk("R2 no freed entry", 32'(free_valid_o), 0);

    // R1 accumulation 3 + 2
    issue(8'h40, 8'h40, 3, 1'b0, 1'b0);
    issue(8'h40, 8'h40, 2, 1'b0, 1'b0);
    for (int t = 1; t <= 4; t++) tick1();
    step();
    chk("R1 not freed after 4 ticks", 32'(free_valid_o), 0);
    tick1();
    step();
    beat("R1 merged", 8'h40, 8'h40, 1'b1, 1'b1);
    step();
    chk("R1 reported once", 32'(free_valid_o), 0);

    // R3 group reservation, unit input ignored
    issue(8'h0C, 8'h80, 2, 1'b1, 1'b0);
    chk("R3 rsv valid", 32'(rsv_valid_o), 1);
    chk("R3 rsv mask",  32'(rsv_mask_o), 32'h0C);
    issue(8'h0C, 8'h55, 1, 1'b1, 1'b0);
    tick1(); tick1(); tick1();
    step();
    beat("R3 group", 8'h0C, 8'h0C, 1'b1, 1'b0);
    step();

    // R4 issue on the same edge as a tick is not lowered by it
    issue(8'h20, 8'h20, 1, 1'b0, 1'b1);
    step();
    chk("R4 same-edge entry kept", 32'(free_valid_o), 0);
    tick1();
    step();
    beat("R4 same-edge", 8'h20, 8'h20, 1'b1, 1'b1);
    step();

    // R8 full table
    issue(8'h01, 8'h01, 1, 1'b0, 1'b0);
    issue(8'h02, 8'h02, 1, 1'b0, 1'b0);
    issue(8'h04, 8'h04, 1, 1'b0, 1'b0);
    issue(8'h08, 8'h08, 1, 1'b0, 1'b0);
    chk("R8 no overflow when fitting", 32'(overflow_o), 0);
    issue(8'h10, 8'h10, 1, 1'b0, 1'b0);
    chk("R8 overflow pulse", 32'(overflow_o), 1);
    issue(8'h20, 8'h20, 0, 1'b0, 1'b0);
    chk("R2 zero-length when full no overflow", 32'(overflow_o), 0);
    chk("R2 zero-length when full released", 32'(imm_rel_valid_o), 1);
    issue(8'h01, 8'h01, 1, 1'b0, 1'b0);
    chk("R8 match when full accepted", 32'(overflow_o), 0);
    tick1();
    step();
    beat("R8 drain a", 8'h02, 8'h02, 1'b0, 1'b1);
    step();
    beat("R8 drain b", 8'h04, 8'h04, 1'b0, 1'b1);
    step();
    beat("R8 drain c", 8'h08, 8'h08, 1'b1, 1'b1);
    step();
    chk("R8 dropped usage never freed", 32'(free_valid_o), 0);
    tick1();
    step();
    beat("R1 merged under full", 8'h01, 8'h01, 1'b1, 1'b1);
    step();

    // R6 R7 R10 ordering and ignored tick
    issue(8'h01, 8'h01, 3, 1'b0, 1'b0); // slot 0
    issue(8'h02, 8'h02, 1, 1'b0, 1'b0); // slot 1
    issue(8'h04, 8'h04, 2, 1'b0, 1'b0); // slot 2
    tick1();                            // slot 1 freed
    chk("R6 no beat on tick edge", 32'(free_valid_o), 0);
    tick1();                            // ignored, pending report
    beat("R7 first burst", 8'h02, 8'h02, 1'b1, 1'b1);
    issue(8'h08, 8'h08, 1, 1'b0, 1'b0); // takes slot 1
    chk("R7 ignored tick freed nothing", 32'(free_valid_o), 0);
    tick1();                            // slots 1 and 2 reach zero
    step();
    beat("R10 lower slot first", 8'h08, 8'h08, 1'b0, 1'b1);
    step();
    beat("R6 second beat", 8'h04, 8'h04, 1'b1, 1'b1);
    step();
    chk("R6 burst ended", 32'(free_valid_o), 0);
    tick1();
    step();
    beat("R7 last entry", 8'h01, 8'h01, 1'b1, 1'b1);
    step();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule